// File: doc/BRIEF.md
# Banked Register File with Per-Bank Port Arbitration

This block is a 64 x 32-bit register file. Full multiporting is replaced by eight banks of eight registers, and each bank has two local read ports and two local write ports. A four-wide issue group presents eight operand reads (two per instruction slot) and four result writes in every cycle. In the same cycle, each bank grants local ports in slot order, steers each granted row address to a local port, and routes the local read data back to the global read port that asked for it.

When a bank runs out of ports, the block does not stall. It raises a per-slot conflict flag in the same cycle. A flagged slot gets no valid read data and its write is dropped, so the issue logic can replay that instruction. Two operands that name the same register share a single local port. An operand marked as bypassed from the previous cycle's results requests no port at all.

Reads are combinational and see the contents from before the current cycle's writes. Writes take effect at the next rising clock edge.

Top module: `bankrf_top`

## Requirements
- R1: After reset, every one of the 64 registers reads as zero.
- R2: Register number bits [2:0] select the bank and bits [5:3] select the row. A granted read returns the last value committed to that register number.
- R3: A read in the same cycle as a write to the same register returns the old value. The new value is readable from the next cycle on. Registers not written keep their value.
- R4: Any number of reads to at most two distinct registers of one bank are granted in the same cycle. Reads of the same register share one local port.
- R5: Global read port g belongs to slot g/2 and has operand index g%2. Requests are handled in ascending g. A request for a third distinct register in a bank sets that slot's conflict flag in the same cycle. A flagged slot has rd_ok low on both of its operands and its write is not committed. Ports taken by a slot that is later flagged stay taken.
- R6: At most two writes per bank are granted, in ascending slot order. A slot whose write would be the third in its bank is flagged, and its write (and its reads) are dropped.
- R7: A read marked bypassed requests no port, drives rd_ok low, and never causes a conflict.
- R8: A global read port whose rd_ok is low drives zero on its rd_data lane.
- R9: When two committed writes in one cycle name the same register, the higher slot's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 8 | Read request per global read port (port g = slot g/2, operand g%2) |
| rd_bypass | input | 8 | Operand is taken from the bypass path; no port is requested |
| rd_addr | input | 48 | Register number per global read port, 6 bits each, port g at [6g+5:6g] |
| wr_req | input | 4 | Write request per slot |
| wr_addr | input | 24 | Register number per slot, 6 bits each |
| wr_data | input | 128 | Write data per slot, 32 bits each |
| rd_data | output | 256 | Read data per global read port, 32 bits each, zero when not valid |
| rd_ok | output | 8 | Read data on this port is valid for its instruction |
| slot_conflict | output | 4 | Slot lost a read or write grant and must be replayed |

## Verification
The bench builds the block with its default parameters: eight banks of eight rows, two read and two write ports per bank, and four slots. With only four slots, a third distinct register in one bank and a third write to one bank are both reachable in a single cycle. Directed cycles cover read sharing, bypass, read-before-write and same-register write collisions. A random phase draws addresses from a small pool so that bank clashes are common, and a queue-based model checks every port on every cycle.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  // operands carried by every instruction slot
  localparam int OPS_PER_SLOT = 2;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bankrf_store.sv
module bankrf_store #(
  parameter int DW    = 32,
  parameter int ROW_W = 3,
  parameter int LRD   = 2,
  parameter int LWR   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LRD*ROW_W-1:0] rrow,
  output logic [LRD*DW-1:0]    rdata,
  input  logic [LWR-1:0]       wen,
  input  logic [LWR*ROW_W-1:0] wrow,
  input  logic [LWR*DW-1:0]    wdata
);
  localparam int ROWS = 1 << ROW_W;

  logic [DW-1:0] mem_q [ROWS];
  logic [DW-1:0] mem_d [ROWS];
  logic [ROWS-1:0] row_hit;

  // next state: higher local write port wins on the same row
  always_comb begin
    for (int r = 0; r < ROWS; r++) mem_d[r] = mem_q[r];
    row_hit = '0;
    for (int k = 0; k < LWR; k++) begin
      if (wen[k]) begin
        mem_d[wrow[k*ROW_W +: ROW_W]] = wdata[k*DW +: DW];
        row_hit[wrow[k*ROW_W +: ROW_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (row_hit[r]) mem_q[r] <= mem_d[r];
      end
    end
  end

  // reads see pre-write contents
  always_comb begin
    for (int p = 0; p < LRD; p++) rdata[p*DW +: DW] = mem_q[rrow[p*ROW_W +: ROW_W]];
  end

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
      assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !((wen != '0) && (
          (wen[0] && wrow[0 +: ROW_W] == ROW_W'(r)) ||
          (wen[LWR-1] && wrow[(LWR-1)*ROW_W +: ROW_W] == ROW_W'(r))))
        && LWR <= 2 |=> $stable(mem_q[r]));
      assert_last_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wen[LWR-1] && wrow[(LWR-1)*ROW_W +: ROW_W] == ROW_W'(r))
        |=> mem_q[r] == $past(wdata[(LWR-1)*DW +: DW]));
    end
  endgenerate
endmodule

// File: rtl/bankrf_rd_arb.sv
module bankrf_rd_arb
  import bankrf_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int LRD   = 2,
  parameter int ROW_W = 3,
  parameter int NRD   = NSLOT * OPS_PER_SLOT,
  parameter int PSW   = sel_width(LRD)
) (
  input  logic [NRD-1:0]       req,
  input  logic [NRD*ROW_W-1:0] row,
  output logic [LRD*ROW_W-1:0] prow,
  output logic [NRD-1:0]       gnt,
  output logic [NRD*PSW-1:0]   psel,
  output logic [NSLOT-1:0]     sfail
);
  logic [ROW_W-1:0] row_a [LRD];
  int used;
  logic hit;

  always_comb begin
    used  = 0;
    gnt   = '0;
    psel  = '0;
    sfail = '0;
    hit   = 1'b0;
    for (int p = 0; p < LRD; p++) row_a[p] = '0;
    for (int g = 0; g < NRD; g++) begin
      if (req[g]) begin
        hit = 1'b0;
        for (int p = 0; p < LRD; p++) begin
          if (!hit && p < used && row_a[p] == row[g*ROW_W +: ROW_W]) begin
            hit = 1'b1;
            gnt[g] = 1'b1;
            psel[g*PSW +: PSW] = PSW'(p);
          end
        end
        if (!hit) begin
          if (used < LRD) begin
            row_a[used] = row[g*ROW_W +: ROW_W];
            psel[g*PSW +: PSW] = PSW'(used);
            gnt[g] = 1'b1;
            used = used + 1;
          end else begin
            sfail[g / OPS_PER_SLOT] = 1'b1;
          end
        end
      end
    end
    for (int p = 0; p < LRD; p++) prow[p*ROW_W +: ROW_W] = row_a[p];
  end
endmodule

// File: rtl/bankrf_wr_arb.sv
module bankrf_wr_arb
  import bankrf_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int LWR   = 2,
  parameter int SW    = sel_width(NSLOT)
) (
  input  logic [NSLOT-1:0]  req,
  output logic [LWR-1:0]    pen,
  output logic [LWR*SW-1:0] pslot,
  output logic [NSLOT-1:0]  sfail
);
  int used;

  always_comb begin
    used  = 0;
    pen   = '0;
    pslot = '0;
    sfail = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (req[s]) begin
        if (used < LWR) begin
          pen[used] = 1'b1;
          pslot[used*SW +: SW] = SW'(s);
          used = used + 1;
        end else begin
          sfail[s] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 3,
  parameter int NSLOT  = 4,
  parameter int LRD    = 2,
  parameter int LWR    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSLOT*OPS_PER_SLOT-1:0] rd_req,
  input  logic [NSLOT*OPS_PER_SLOT-1:0] rd_bypass,
  input  logic [NSLOT*OPS_PER_SLOT*(BANK_W+ROW_W)-1:0] rd_addr,
  input  logic [NSLOT-1:0]              wr_req,
  input  logic [NSLOT*(BANK_W+ROW_W)-1:0] wr_addr,
  input  logic [NSLOT*DW-1:0]           wr_data,
  output logic [NSLOT*OPS_PER_SLOT*DW-1:0] rd_data,
  output logic [NSLOT*OPS_PER_SLOT-1:0] rd_ok,
  output logic [NSLOT-1:0]              slot_conflict
);
  localparam int AW    = BANK_W + ROW_W;
  localparam int NBANK = 1 << BANK_W;
  localparam int NRD   = NSLOT * OPS_PER_SLOT;
  localparam int PSW   = sel_width(LRD);
  localparam int SW    = sel_width(NSLOT);

  logic [NRD*ROW_W-1:0] rrow_all;
  logic [NRD-1:0]       rgnt_a  [NBANK];
  logic [NRD*PSW-1:0]   psel_a  [NBANK];
  logic [NSLOT-1:0]     rfail_a [NBANK];
  logic [NSLOT-1:0]     wfail_a [NBANK];
  logic [LRD*DW-1:0]    rdat_a  [NBANK];

  always_comb begin
    for (int g = 0; g < NRD; g++) rrow_all[g*ROW_W +: ROW_W] = rd_addr[g*AW+BANK_W +: ROW_W];
  end

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [NRD-1:0]       rreq;
      logic [NSLOT-1:0]     wreq;
      logic [LRD*ROW_W-1:0] prow;
      logic [LWR-1:0]       wpen;
      logic [LWR-1:0]       wen;
      logic [LWR*SW-1:0]    wpslot;
      logic [LWR*ROW_W-1:0] wrow;
      logic [LWR*DW-1:0]    wdat;

      always_comb begin
        for (int g = 0; g < NRD; g++)
          rreq[g] = rd_req[g] && !rd_bypass[g] && (rd_addr[g*AW +: BANK_W] == BANK_W'(b));
        for (int s = 0; s < NSLOT; s++)
          wreq[s] = wr_req[s] && (wr_addr[s*AW +: BANK_W] == BANK_W'(b));
      end

      bankrf_rd_arb #(.NSLOT(NSLOT), .LRD(LRD), .ROW_W(ROW_W), .NRD(NRD), .PSW(PSW)) u_rd_arb (
        .req(rreq), .row(rrow_all), .prow(prow),
        .gnt(rgnt_a[b]), .psel(psel_a[b]), .sfail(rfail_a[b]));

      bankrf_wr_arb #(.NSLOT(NSLOT), .LWR(LWR), .SW(SW)) u_wr_arb (
        .req(wreq), .pen(wpen), .pslot(wpslot), .sfail(wfail_a[b]));

      // local write port k carries the slot picked by the write arbiter
      always_comb begin
        for (int k = 0; k < LWR; k++) begin
          wen[k] = wpen[k] && !slot_conflict[wpslot[k*SW +: SW]];
          wrow[k*ROW_W +: ROW_W] = wr_addr[int'(wpslot[k*SW +: SW])*AW+BANK_W +: ROW_W];
          wdat[k*DW +: DW] = wr_data[int'(wpslot[k*SW +: SW])*DW +: DW];
        end
      end

      bankrf_store #(.DW(DW), .ROW_W(ROW_W), .LRD(LRD), .LWR(LWR)) u_store (
        .clk(clk), .rst_n(rst_n), .rrow(prow), .rdata(rdat_a[b]),
        .wen(wen), .wrow(wrow), .wdata(wdat));

      for (genvar g = 0; g < NRD; g++) begin : g_port_chk
        assert_port_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
          rgnt_a[b][g] |-> prow[int'(psel_a[b][g*PSW +: PSW])*ROW_W +: ROW_W]
                           == rd_addr[g*AW+BANK_W +: ROW_W]);
      end
      for (genvar s = 0; s < NSLOT; s++) begin : g_wr_chk
        assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
          wfail_a[b][s] |-> $countones(wreq & NSLOT'((1 << s) - 1)) >= LWR);
      end
    end
  endgenerate

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      slot_conflict[s] = 1'b0;
      for (int b = 0; b < NBANK; b++)
        slot_conflict[s] = slot_conflict[s] | rfail_a[b][s] | wfail_a[b][s];
    end
  end

  // return path: bank of the operand, then the local port it was given
  always_comb begin
    for (int g = 0; g < NRD; g++) begin
      int bk;
      int pt;
      bk = int'(rd_addr[g*AW +: BANK_W]);
      pt = int'(psel_a[bk][g*PSW +: PSW]);
      rd_ok[g] = rd_req[g] && !rd_bypass[g] && !slot_conflict[g / OPS_PER_SLOT];
      rd_data[g*DW +: DW] = rd_ok[g] ? rdat_a[bk][pt*DW +: DW] : '0;
    end
  end

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_out_chk
      assert_bypass_noread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bypass[g] |-> !rd_ok[g]);
      assert_conflict_kills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_conflict[g / OPS_PER_SLOT] |-> !rd_ok[g] && rd_data[g*DW +: DW] == '0);
    end
  endgenerate
endmodule

// File: tb/bankrf_top_bench.sv
`timescale 1ns/1ps
module bankrf_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]   rd_req, rd_bypass, rd_ok;
  logic [47:0]  rd_addr;
  logic [3:0]   wr_req, slot_conflict;
  logic [23:0]  wr_addr;
  logic [127:0] wr_data;
  logic [255:0] rd_data;

  bankrf_top u_bankrf_top (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_bypass(rd_bypass),
    .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_ok(rd_ok), .slot_conflict(slot_conflict));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit rv [8];
  bit rb [8];
  int ra [8];
  bit wv [4];
  int wa [4];
  logic [31:0] wd [4];
  logic [31:0] mdl [64];

  task automatic chk(bit good, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int g = 0; g < 8; g++) begin rv[g] = 0; rb[g] = 0; ra[g] = 0; end
    for (int s = 0; s < 4; s++) begin wv[s] = 0; wa[s] = 0; wd[s] = '0; end
  endtask

  task automatic step(string tag);
    int rows [8][$];
    int wcnt [8];
    bit fail [4];
    logic [3:0] efail;
    @(negedge clk);
    for (int g = 0; g < 8; g++) begin
      rd_req[g] = rv[g]; rd_bypass[g] = rb[g]; rd_addr[g*6 +: 6] = ra[g][5:0];
    end
    for (int s = 0; s < 4; s++) begin
      wr_req[s] = wv[s]; wr_addr[s*6 +: 6] = wa[s][5:0]; wr_data[s*32 +: 32] = wd[s];
    end
    #2;
    for (int b = 0; b < 8; b++) wcnt[b] = 0;
    for (int s = 0; s < 4; s++) fail[s] = 0;
    for (int g = 0; g < 8; g++) begin
      if (rv[g] && !rb[g]) begin
        int b;
        bit seen;
        b = ra[g] % 8;
        seen = 0;
        foreach (rows[b][i]) if (rows[b][i] == ra[g]) seen = 1;
        if (!seen) begin
          if (rows[b].size() < 2) rows[b].push_back(ra[g]);
          else fail[g/2] = 1;
        end
      end
    end
    for (int s = 0; s < 4; s++) begin
      if (wv[s]) begin
        if (wcnt[wa[s] % 8] < 2) wcnt[wa[s] % 8]++;
        else fail[s] = 1;
      end
    end
    for (int s = 0; s < 4; s++) efail[s] = fail[s];
    chk(slot_conflict == efail, tag, "slot_conflict", 64'(slot_conflict), 64'(efail));
    for (int g = 0; g < 8; g++) begin
      bit eok;
      logic [31:0] ed;
      eok = rv[g] && !rb[g] && !fail[g/2];
      ed = eok ? mdl[ra[g]] : 32'h0;
      chk(rd_ok[g] == eok, tag, $sformatf("rd_ok[%0d]", g), 64'(rd_ok[g]), 64'(eok));
      chk(rd_data[g*32 +: 32] == ed, tag, $sformatf("rd_data[%0d]", g),
          64'(rd_data[g*32 +: 32]), 64'(ed));
    end
    for (int s = 0; s < 4; s++) if (wv[s] && !fail[s]) mdl[wa[s]] = wd[s];
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    clr();
    rd_req = '0; rd_bypass = '0; rd_addr = '0; wr_req = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all registers zero after reset
    for (int c = 0; c < 8; c++) begin
      clr();
      for (int g = 0; g < 8; g++) begin rv[g] = 1; ra[g] = c*8 + g; end
      step("R1");
    end
    // R2: fill every register, four different banks per cycle, then read back
    for (int c = 0; c < 16; c++) begin
      clr();
      for (int s = 0; s < 4; s++) begin
        wv[s] = 1; wa[s] = c*4 + s; wd[s] = 32'hC0DE0000 | 32'((c*4 + s) * 257);
      end
      step("R2");
    end
    for (int c = 0; c < 8; c++) begin
      clr();
      for (int g = 0; g < 8; g++) begin rv[g] = 1; ra[g] = ((c + g) % 8) * 8 + g; end
      step("R2");
    end
    // R3: read in the write cycle sees old data, next cycle sees new
    clr(); wv[0] = 1; wa[0] = 5; wd[0] = 32'h1234_5678;
    rv[0] = 1; ra[0] = 5; rv[1] = 1; ra[1] = 5; step("R3");
    clr(); rv[0] = 1; ra[0] = 5; rv[2] = 1; ra[2] = 13; step("R3");
    // R4: two distinct rows in one bank, then one shared register
    clr(); for (int g = 0; g < 8; g++) begin rv[g] = 1; ra[g] = (g % 2) ? 8 : 0; end
    step("R4");
    clr(); for (int g = 0; g < 8; g++) begin rv[g] = 1; ra[g] = 16; end
    step("R4");
    // R5: third distinct register in bank 3 from slot 1; its write is dropped
    clr(); rv[0] = 1; ra[0] = 3; rv[1] = 1; ra[1] = 11; rv[2] = 1; ra[2] = 19;
    rv[3] = 1; ra[3] = 3; rv[4] = 1; ra[4] = 11; rv[5] = 1; ra[5] = 3;
    wv[1] = 1; wa[1] = 27; wd[1] = 32'hDEAD_BEEF; step("R5");
    clr(); rv[0] = 1; ra[0] = 27; step("R5");
    // R6: three writes to bank 2
    clr(); for (int s = 0; s < 3; s++) begin wv[s] = 1; wa[s] = 2 + 8*s; wd[s] = 32'hF00 + 32'(s); end
    step("R6");
    clr(); rv[0] = 1; ra[0] = 2; rv[1] = 1; ra[1] = 10; rv[2] = 1; ra[2] = 18; step("R6");
    // R7: bypassed operands do not consume ports
    clr(); for (int g = 0; g < 6; g++) begin rv[g] = 1; ra[g] = 1 + 8*g; rb[g] = (g >= 2); end
    step("R7");
    // R9: same register written by slots 0 and 3
    clr(); wv[0] = 1; wa[0] = 44; wd[0] = 32'hAAAA_0000; wv[3] = 1; wa[3] = 44; wd[3] = 32'hBBBB_1111;
    step("R9");
    clr(); rv[0] = 1; ra[0] = 44; step("R9");
    // R8: idle ports drive zero; random traffic with frequent bank clashes
    clr(); step("R8");
    for (int n = 0; n < 400; n++) begin
      clr();
      for (int g = 0; g < 8; g++) begin
        rv[g] = ($urandom_range(0, 3) != 0);
        rb[g] = ($urandom_range(0, 3) == 0);
        ra[g] = ($urandom_range(0, 1) != 0) ? 8 * $urandom_range(0, 3) + $urandom_range(0, 1)
                                            : $urandom_range(0, 63);
      end
      for (int s = 0; s < 4; s++) begin
        wv[s] = ($urandom_range(0, 1) != 0);
        wa[s] = 8 * $urandom_range(0, 7) + $urandom_range(0, 2);
        wd[s] = $urandom;
      end
      step("R8");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule